// File: doc/BRIEF.md
# Double-to-single store narrowing converter

This block narrows a 64-bit double-precision register image into the 32-bit single-precision word that a store-single operation writes to memory. It does not round. Fraction bits below the single-precision field are discarded. Exponent and fraction fields are copied bit for bit whenever the double's exponent is at or above the smallest single-precision normal exponent. The same path serves zero, infinity, NaN and magnitudes too large for single precision. None of these is saturated. Values that fall into the single-precision subnormal range are denormalized by shifting the hidden one into the fraction. Anything smaller becomes a zero that keeps its sign.

Data enters on a valid/ready stream and leaves from a registered output stage that has its own valid/ready pair. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. The narrowed word appears on `out_data` with `out_valid` set one cycle later. A result that is not taken stays on the output unchanged. While it is held, `in_ready` is low. When the consumer takes the current word, the stage can load a new one in the same cycle, so a sustained stream has no bubbles.

Top module: `fp64_store_narrow`

## Requirements
- R1: Output bit 31 always equals input bit 63 (the sign), on every path.
- R2: When the biased exponent field (input bits 62..52) is 897 or more, the output is the sign, then input bit 62, then input bits 58..52, then input bits 51..29. Infinity, NaN and oversize values take this path and are not saturated.
- R3: When input bits 62..0 are all zero, the output is a zero carrying the input sign.
- R4: When the biased exponent is between 874 and 896 inclusive, output bits 30..23 are zero. Output bits 22..0 are the low 23 bits of the 24-bit value {1, input bits 51..29} shifted right by 897 minus the exponent, which is a shift of 1 to 23.
- R5: When the biased exponent is below 874 and input bits 62..0 are not all zero, output bits 30..0 are zero. Double subnormals are included.
- R6: Discarded fraction bits never change the result. Input bits 28..0 have no effect on any path, and truncation never rounds up.
- R7: A word accepted on a clock edge is presented with `out_valid` high directly after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: With `out_ready` held high, a new word is accepted on every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_data | input | 64 | Double-precision register image |
| out_valid | output | 1 | Narrowed word available |
| out_ready | input | 1 | Consumer takes the narrowed word |
| out_data | output | 32 | Single-precision memory word |

## Verification
The output stage can drain the word it holds and load the next one on the same edge. The bench provokes this by driving `in_valid` and `out_ready` with independent random patterns. Many cycles therefore present a word to the consumer while a new input is offered. Each drained word is compared in order against a queue of expected values, which are computed when each input is accepted. A word that is lost, repeated or overwritten on such a coincident edge shows up as a mismatch or as a latency failure. Held words are checked for stability on every stalled cycle.

// File: rtl/fp64n_pkg.sv
package fp64n_pkg;
  parameter int SRC_W      = 64;
  parameter int SRC_EXP_W  = 11;
  parameter int SRC_FRAC_W = 52;
  parameter int DST_W      = 32;
  parameter int DST_EXP_W  = 8;
  parameter int DST_FRAC_W = 23;

  localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
  localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;
  // biased source exponent of the smallest destination normal
  localparam int MIN_NORM_E = SRC_BIAS - DST_BIAS + 1;
  // smallest biased source exponent still reachable as a subnormal
  localparam int TINY_E     = MIN_NORM_E - DST_FRAC_W;
  localparam int SHIFT_W    = $clog2(DST_FRAC_W + 1);

  typedef enum logic [1:0] {
    PATH_COPY   = 2'd0,
    PATH_DENORM = 2'd1,
    PATH_FLUSH  = 2'd2
  } path_t;
endpackage

// File: rtl/fp64n_classify.sv
module fp64n_classify
  import fp64n_pkg::*;
(
  input  logic [SRC_W-2:0]   mag,
  output path_t              path,
  output logic [SHIFT_W-1:0] shift
);
  logic [SRC_EXP_W-1:0] e_fld;
  logic                 mag_zero;

  assign e_fld    = mag[SRC_W-2 -: SRC_EXP_W];
  assign mag_zero = (mag == '0);
  // modulo arithmetic is exact because the band keeps the shift in 1..23
  assign shift    = SHIFT_W'(MIN_NORM_E) - e_fld[SHIFT_W-1:0];

  always_comb begin
    if (mag_zero || e_fld >= SRC_EXP_W'(MIN_NORM_E))
      path = PATH_COPY;
    else if (e_fld >= SRC_EXP_W'(TINY_E))
      path = PATH_DENORM;
    else
      path = PATH_FLUSH;
  end
endmodule

// File: rtl/fp64n_denorm.sv
module fp64n_denorm
  import fp64n_pkg::*;
(
  input  logic [DST_FRAC_W-1:0] frac_hi,
  input  logic [SHIFT_W-1:0]    shift,
  output logic [DST_FRAC_W-1:0] frac
);
  localparam int EXT_W = DST_FRAC_W + (1 << SHIFT_W);
  localparam int IDX_W = $clog2(EXT_W);

  logic [EXT_W-1:0] ext;
  assign ext = EXT_W'({1'b1, frac_hi});

  for (genvar b = 0; b < DST_FRAC_W; b++) begin : g_bit
    assign frac[b] = ext[IDX_W'(b) + IDX_W'(shift)];
  end
endmodule

// File: rtl/fp64n_out_stage.sv
module fp64n_out_stage
  import fp64n_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [DST_W-1:0] load_data,
  output logic             can_load,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DST_W-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load_valid && can_load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_reset_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: rtl/fp64_store_narrow.sv
module fp64_store_narrow
  import fp64n_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DST_W-1:0] out_data
);
  path_t                 path;
  logic [SHIFT_W-1:0]    shift;
  logic [DST_FRAC_W-1:0] den_frac;
  logic [DST_W-1:0]      word;
  logic                  sign;

  assign sign = in_data[SRC_W-1];

  fp64n_classify u_classify (
    .mag   (in_data[SRC_W-2:0]),
    .path  (path),
    .shift (shift)
  );

  fp64n_denorm u_denorm (
    .frac_hi (in_data[SRC_FRAC_W-1 -: DST_FRAC_W]),
    .shift   (shift),
    .frac    (den_frac)
  );

  always_comb begin
    unique case (path)
      PATH_COPY:   word = {sign, in_data[SRC_W-2],
                           in_data[SRC_FRAC_W + DST_EXP_W - 2 : SRC_FRAC_W],
                           in_data[SRC_FRAC_W-1 : DROP_W]};
      PATH_DENORM: word = {sign, {DST_EXP_W{1'b0}}, den_frac};
      default:     word = {sign, {(DST_W-1){1'b0}}};
    endcase
  end

  fp64n_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_data  (word),
    .can_load   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

  // assertion-side view of the input exponent
  logic [SRC_EXP_W-1:0] chk_exp;
  logic                 chk_acc;
  assign chk_exp = in_data[SRC_W-2 -: SRC_EXP_W];
  assign chk_acc = in_valid && in_ready;

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_acc |=> (out_data[DST_W-1] == $past(in_data[SRC_W-1])));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_acc |=> out_valid);

  p_copy_exp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_acc && chk_exp >= SRC_EXP_W'(MIN_NORM_E)) |=>
      (out_data[DST_W-2:DST_FRAC_W] ==
       {$past(in_data[SRC_W-2]), $past(in_data[SRC_FRAC_W + DST_EXP_W - 2 : SRC_FRAC_W])}));

  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_acc && in_data[SRC_W-2:0] == '0) |=> (out_data[DST_W-2:0] == '0));

  p_denorm_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_acc && chk_exp >= SRC_EXP_W'(TINY_E) && chk_exp < SRC_EXP_W'(MIN_NORM_E)) |=>
      (out_data[DST_W-2:DST_FRAC_W] == '0 && out_data[DST_FRAC_W-1:0] != '0));

  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_acc && chk_exp < SRC_EXP_W'(TINY_E)) |=> (out_data[DST_W-2:0] == '0));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/fp64_store_narrow_tb_top.sv
`timescale 1ns/1ps
module fp64_store_narrow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  logic [63:0] src_q[$];
  bit          prev_acc   = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_data  = '0;
  int          acc_count  = 0;

  always #2 clk = ~clk;

  fp64_store_narrow dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] ref_word(input logic [63:0] d);
    int e, sh;
    logic [23:0] m, q;
    e = int'(d[62:52]);
    if (d[62:0] == '0 || e > 896) return {d[63], d[62], d[58:52], d[51:29]};
    if (e >= 874) begin
      sh = 897 - e;
      m  = {1'b1, d[51:29]};
      q  = m >> sh;
      return {d[63], 8'h00, q[22:0]};
    end
    return {d[63], 31'h0};
  endfunction

  function automatic string req_tag(input logic [63:0] d);
    int e;
    e = int'(d[62:52]);
    if (d[62:0] == '0) return "R3";
    if (e > 896)       return (d[28:0] != 0) ? "R2 R6" : "R2";
    if (e >= 874)      return (d[28:0] != 0) ? "R4 R6" : "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] d, input bit r);
    logic [31:0] e;
    logic [63:0] s;
    if (prev_acc)   check(out_valid == 1'b1, "R7", 64'(out_valid), 64'd1);
    if (prev_stall) check(out_valid && out_data == prev_data, "R8",
                          64'(out_data), 64'(prev_data));
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    #1;
    if (out_valid && !out_ready)
      check(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", 64'(out_data), 64'hx);
      end else begin
        e = exp_q.pop_front();
        s = src_q.pop_front();
        check(out_data == e, req_tag(s), 64'(out_data), 64'(e));
        check(out_data[31] == s[63], "R1", 64'(out_data[31]), 64'(s[63]));
      end
    end
    prev_acc   = v && in_ready;
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (prev_acc) begin
      exp_q.push_back(ref_word(d));
      src_q.push_back(d);
      acc_count++;
    end
    @(negedge clk);
  endtask

  function automatic logic [63:0] rand_double();
    logic [51:0] f;
    logic [10:0] e;
    int band;
    f = {20'($urandom()), $urandom()};
    band = $urandom_range(0, 5);
    case (band)
      0: e = 11'($urandom_range(897, 2046));
      1: e = 11'($urandom_range(874, 896));
      2: e = 11'($urandom_range(0, 873));
      3: e = 11'd2047;
      4: begin e = 11'd0; if ($urandom_range(0, 1) == 0) f = '0; end
      default: e = 11'($urandom_range(870, 900));
    endcase
    return {1'($urandom()), e, f};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] vec [14];
    void'($urandom(32'h5eed_1234));
    vec[0]  = 64'h0000000000000000;
    vec[1]  = 64'h8000000000000000;
    vec[2]  = 64'h7FF0000000000000;
    vec[3]  = 64'hFFF8000000000001;
    vec[4]  = 64'h3FF0000000000000;
    vec[5]  = 64'h7FEFFFFFFFFFFFFF;
    vec[6]  = 64'h3810000000000000;
    vec[7]  = 64'h380FFFFFFFFFFFFF;
    vec[8]  = 64'h36A0000000000000;
    vec[9]  = 64'h3690000000000000;
    vec[10] = 64'h000FFFFFFFFFFFFF;
    vec[11] = 64'hB80FFFFFE0000000;
    vec[12] = 64'h3FFFFFFFFFFFFFFF;
    vec[13] = 64'h3FFFFFFFE0000000;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners, one at a time
    for (int i = 0; i < 14; i++) begin
      step(1'b1, vec[i], 1'b1);
      step(1'b0, '0, 1'b1);
    end
    // R6: bits below the kept field have no effect
    check(ref_word(vec[12]) == ref_word(vec[13]), "R6",
          64'(ref_word(vec[12])), 64'(ref_word(vec[13])));

    // R10: back-to-back burst
    acc_count = 0;
    for (int i = 0; i < 8; i++) step(1'b1, rand_double(), 1'b1);
    check(acc_count == 8, "R10", 64'(acc_count), 64'd8);
    step(1'b0, '0, 1'b1);

    // stall with a pending offer, then drain and load together
    step(1'b1, vec[4], 1'b0);
    step(1'b1, vec[7], 1'b0);
    step(1'b1, vec[7], 1'b0);
    step(1'b1, vec[7], 1'b1);
    step(1'b0, '0, 1'b1);

    // random traffic
    for (int i = 0; i < 4000; i++)
      step(($urandom_range(0, 3) != 0), rand_double(), ($urandom_range(0, 2) != 0));

    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    check(exp_q.size() == 0, "R7", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule